// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits on the bus side of a byte-wide parallel NOR flash model. It watches the chip-enable, write-enable and output-enable strobes, the address bus and the data bus. It follows the multi-cycle unlock handshake that must come before every command and decides which mode the device is in. The modes are read-array, identifier read, program in progress and chip erase in progress. When a program or chip-erase sequence completes, the block issues a one-cycle start pulse and the latched command address and data to the embedded-algorithm engine. It then ignores further writes until that engine reports completion or reports a timeout.

The strobes and buses are sampled on the block clock. The write strobe is asserted while chip-enable and write-enable are both low. The address is captured on the cycle in which that strobe becomes asserted, which is when the later of the two enables falls. The data is captured from the last cycle in which the strobe was still asserted, which is when the earlier of the two enables rises. In identifier mode the block supplies the byte to drive onto the data bus together with an enable.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read array), `pgm_start` and `erase_start` are low, and `id_oe` is low.
- R2: The mode is held until a complete command sequence changes it. In identifier mode, a write of F0h returns the block to read-array mode (0).
- R3: In identifier mode (`mode`=1), a read with CE# and OE# low and WE# high raises `id_oe`. The read returns `MFG_CODE` at low address byte 00h, returns `DEV_CODE` at 01h and returns 00h at offsets 03h to FFh. Outside identifier mode `id_oe` stays low.
- R4: In identifier mode, a read at low address byte 02h returns a byte with bit 0 equal to `wp_flags[addr[18:16]]` and bits 7:1 equal to zero.
- R5: The write sequence 555h/AAh, 2AAh/55h, 555h/A0h, then any address/data pulses `pgm_start` for one cycle. It sets `cmd_addr` and `cmd_data` to the fourth cycle's address and data and sets `mode` to 2. Unlock addresses are compared on address bits 10:0 only.
- R6: The write sequence 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h pulses `erase_start` for one cycle and sets `mode` to 3.
- R7: A write's address is the one present when the later of CE# and WE# falls. Its data is the one present in the last sampled cycle before the earlier of them rises.
- R8: While `mode` is 2 or 3, writes have no effect and no start pulse is issued. A cycle with `eng_done` high returns `mode` to 0.
- R9: Any write that does not match the next expected cycle of a sequence abandons the sequence and returns `mode` to 0.
- R10: While `mode` is 2 or 3 and `eng_timeout` is high, a write of F0h returns `mode` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| dq_in | input | 8 | Data bus as driven by the host |
| wp_flags | input | NSEC | Write-protect flag per sector |
| eng_done | input | 1 | Embedded engine finished normally |
| eng_timeout | input | 1 | Embedded engine exceeded its time limit |
| mode | output | 2 | 0 read array, 1 identifier, 2 programming, 3 erasing |
| id_oe | output | 1 | Drive `id_data` onto the data bus |
| id_data | output | 8 | Identifier or protect byte |
| pgm_start | output | 1 | One-cycle program start pulse |
| erase_start | output | 1 | One-cycle chip-erase start pulse |
| cmd_addr | output | AW | Latched program address |
| cmd_data | output | 8 | Latched program data |

## Verification
A corrupted sequence state shows up at the ports no later than the end of the write that completes the affected command. On that write, a start pulse is missing or appears where none is expected, or `mode` differs from the expected value. A corrupted mode register shows up at once through `id_oe` on the next identifier read, or through a start pulse that leaks out during a busy period. An error in edge selection shows up on the `cmd_addr` and `cmd_data` that go with the next program pulse. The bench therefore compares `mode` and both pulses after every write, and compares the identifier bytes after every read.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 19,
  parameter int ULW = 11,
  parameter int NSEC = 8,
  parameter logic [7:0] MFG_CODE = 8'h52,
  parameter logic [7:0] DEV_CODE = 8'hA4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      dq_in,
  input  logic [NSEC-1:0] wp_flags,
  input  logic            eng_done,
  input  logic            eng_timeout,
  output logic [1:0]      mode,
  output logic            id_oe,
  output logic [7:0]      id_data,
  output logic            pgm_start,
  output logic            erase_start,
  output logic [AW-1:0]   cmd_addr,
  output logic [7:0]      cmd_data
);
  localparam int SB = $clog2(NSEC);
  localparam logic [ULW-1:0] KEY_A = ULW'('h555);
  localparam logic [ULW-1:0] KEY_B = ULW'('h2AA);
  localparam logic [1:0] M_RD = 2'd0, M_ID = 2'd1, M_PG = 2'd2, M_ER = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PD, S_ES, S_E1, S_E2} seq_t;

  seq_t seq_q, seq_n;
  logic [1:0] mode_q, mode_n;
  logic wr, wr_q, pgm_go, ers_go;
  logic [AW-1:0] addr_lat;
  logic [7:0] dq_q;

  assign wr = !ce_n && !we_n;
  wire strobe_on  = wr && !wr_q;
  wire strobe_off = !wr && wr_q;
  wire at_a  = addr_lat[ULW-1:0] == KEY_A;
  wire key1  = at_a && dq_q == 8'hAA;
  wire key2  = addr_lat[ULW-1:0] == KEY_B && dq_q == 8'h55;

  always_comb begin
    mode_n = mode_q;
    seq_n  = seq_q;
    pgm_go = 1'b0;
    ers_go = 1'b0;
    if (mode_q[1]) begin
      if (eng_done || (strobe_off && eng_timeout && dq_q == 8'hF0)) begin
        mode_n = M_RD;
        seq_n  = S_IDLE;
      end
    end else if (strobe_off) begin
      mode_n = M_RD;
      seq_n  = S_IDLE;
      case (seq_q)
        S_IDLE: if (key1) begin seq_n = S_U1; mode_n = mode_q; end
        S_U1:   if (key2) begin seq_n = S_U2; mode_n = mode_q; end
        S_U2: begin
          if (at_a && dq_q == 8'h90) mode_n = M_ID;
          else if (at_a && dq_q == 8'hA0) begin seq_n = S_PD; mode_n = mode_q; end
          else if (at_a && dq_q == 8'h80) begin seq_n = S_ES; mode_n = mode_q; end
        end
        S_PD: begin pgm_go = 1'b1; mode_n = M_PG; end
        S_ES:   if (key1) begin seq_n = S_E1; mode_n = mode_q; end
        S_E1:   if (key2) begin seq_n = S_E2; mode_n = mode_q; end
        S_E2:   if (at_a && dq_q == 8'h10) begin ers_go = 1'b1; mode_n = M_ER; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q        <= 1'b0;
      dq_q        <= '0;
      addr_lat    <= '0;
      seq_q       <= S_IDLE;
      mode_q      <= M_RD;
      pgm_start   <= 1'b0;
      erase_start <= 1'b0;
      cmd_addr    <= '0;
      cmd_data    <= '0;
    end else begin
      wr_q        <= wr;
      dq_q        <= dq_in;
      if (strobe_on) addr_lat <= addr;
      seq_q       <= seq_n;
      mode_q      <= mode_n;
      pgm_start   <= pgm_go;
      erase_start <= ers_go;
      if (pgm_go) begin
        cmd_addr <= addr_lat;
        cmd_data <= dq_q;
      end
    end
  end

  logic [7:0] id_byte;
  always_comb begin
    case (addr[7:0])
      8'h00:   id_byte = MFG_CODE;
      8'h01:   id_byte = DEV_CODE;
      8'h02:   id_byte = {7'd0, wp_flags[addr[AW-1 -: SB]]};
      default: id_byte = 8'h00;
    endcase
  end

  assign mode    = mode_q;
  assign id_oe   = mode_q == M_ID && !ce_n && !oe_n && we_n;
  assign id_data = id_byte;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          eng_done,
  input logic          eng_timeout,
  input logic [1:0]    mode,
  input logic          id_oe,
  input logic [7:0]    id_data,
  input logic          pgm_start,
  input logic          erase_start
);
  AST_RESET_READ: assert property (@(posedge clk) !rst_n |=> (mode == 2'd0 && !pgm_start && !erase_start)); // R1
  AST_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({pgm_start, erase_start})); // R5
  AST_PGM_MODE: assert property (@(posedge clk) disable iff (!rst_n) pgm_start |-> mode == 2'd2); // R5
  AST_ERASE_MODE: assert property (@(posedge clk) disable iff (!rst_n) erase_start |-> mode == 2'd3); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mode[1] && !eng_done && !eng_timeout) |=> $stable(mode)); // R8
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n) mode[1] |=> !(pgm_start || erase_start)); // R8
  AST_PROT_BYTE: assert property (@(posedge clk) disable iff (!rst_n) (id_oe && addr[7:0] == 8'h02) |-> id_data[7:1] == 7'd0); // R4
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .eng_done(eng_done), .eng_timeout(eng_timeout),
  .mode(mode), .id_oe(id_oe), .id_data(id_data), .pgm_start(pgm_start), .erase_start(erase_start)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
  localparam logic [7:0] MFG = 8'h52, DEV = 8'hA4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0] dq = '0;
  logic [7:0] wp = 8'b1010_0110;
  logic eng_done = 1'b0, eng_timeout = 1'b0;
  logic [1:0] mode;
  logic id_oe, pgm_start, erase_start;
  logic [7:0] id_data, cmd_data;
  logic [18:0] cmd_addr;

  int total = 0, bad = 0;
  int m_mode = 0, m_seq = 0;
  bit m_to = 0, e_pgm, e_ers, g_pgm, g_ers;
  logic [18:0] e_a;
  logic [7:0] e_d;

  always #2 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .dq_in(dq), .wp_flags(wp), .eng_done(eng_done), .eng_timeout(eng_timeout),
    .mode(mode), .id_oe(id_oe), .id_data(id_data), .pgm_start(pgm_start),
    .erase_start(erase_start), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [18:0] a, input logic [7:0] d);
    bit k1, k2, c5;
    e_pgm = 0; e_ers = 0;
    k1 = a[10:0] == 11'h555 && d == 8'hAA;
    k2 = a[10:0] == 11'h2AA && d == 8'h55;
    c5 = a[10:0] == 11'h555;
    if (m_mode >= 2) begin
      if (m_to && d == 8'hF0) begin m_mode = 0; m_seq = 0; end
      return;
    end
    case (m_seq)
      0: if (k1) m_seq = 1; else begin m_mode = 0; m_seq = 0; end
      1: if (k2) m_seq = 2; else begin m_mode = 0; m_seq = 0; end
      2: begin
        m_seq = 0;
        if (c5 && d == 8'h90) m_mode = 1;
        else if (c5 && d == 8'hA0) m_seq = 3;
        else if (c5 && d == 8'h80) m_seq = 4;
        else m_mode = 0;
      end
      3: begin e_pgm = 1; e_a = a; e_d = d; m_mode = 2; m_seq = 0; end
      4: if (k1) m_seq = 5; else begin m_mode = 0; m_seq = 0; end
      5: if (k2) m_seq = 6; else begin m_mode = 0; m_seq = 0; end
      default: begin
        m_seq = 0;
        if (c5 && d == 8'h10) begin e_ers = 1; m_mode = 3; end else m_mode = 0;
      end
    endcase
  endtask

  task automatic bus_write(input logic [18:0] a, input logic [7:0] d, input bit ce_last);
    @(negedge clk); addr = a ^ 19'h1F0F0; dq = ~d;
    if (ce_last) we_n = 1'b0; else ce_n = 1'b0;
    @(negedge clk); addr = a;
    if (ce_last) ce_n = 1'b0; else we_n = 1'b0;
    @(negedge clk); addr = ~a; dq = d;
    @(negedge clk);
    if (ce_last) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; dq = ~d; addr = a ^ 19'h00F00;
    g_pgm = pgm_start; g_ers = erase_start;
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d, input string tag);
    bus_write(a, d, $urandom % 2);
    model(a, d);
    chk(mode == m_mode[1:0], {tag, " mode"}, mode, m_mode);
    chk(g_pgm == e_pgm, {tag, " pgm_start"}, g_pgm, e_pgm);
    chk(g_ers == e_ers, {tag, " erase_start"}, g_ers, e_ers);
    if (e_pgm) begin
      chk(cmd_addr == e_a, {tag, " R7 cmd_addr"}, cmd_addr, e_a);
      chk(cmd_data == e_d, {tag, " R7 cmd_data"}, cmd_data, e_d);
    end
    if (m_mode < 2 && m_to) begin m_to = 0; eng_timeout = 1'b0; end
  endtask

  function automatic logic [7:0] id_exp(input logic [18:0] a);
    case (a[7:0])
      8'h00: return MFG;
      8'h01: return DEV;
      8'h02: return {7'd0, wp[a[18:16]]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic id_read(input logic [18:0] a, input string tag);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; #1;
    chk(id_oe == (m_mode == 1), {tag, " id_oe"}, id_oe, m_mode == 1);
    if (m_mode == 1) chk(id_data == id_exp(a), {tag, " id_data"}, id_data, id_exp(a));
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    if (m_mode >= 2) begin m_mode = 0; m_seq = 0; end
    m_to = 0; eng_timeout = 1'b0;
    chk(mode == m_mode[1:0], "R8 done", mode, m_mode);
  endtask

  function automatic logic [18:0] hi(input logic [10:0] lo);
    return {8'($urandom), lo};
  endfunction

  task automatic unlock(input logic [7:0] c, input string tag);
    wr(hi(11'h555), 8'hAA, tag);
    wr(hi(11'h2AA), 8'h55, tag);
    wr(hi(11'h555), c, tag);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode == 2'd0, "R1 reset mode", mode, 0);
    chk(!pgm_start && !erase_start, "R1 reset pulses", {pgm_start, erase_start}, 0);
    id_read(19'h00000, "R1 R3");

    wr(19'h12345, 8'h3C, "R2 junk");
    unlock(8'h90, "R3 enter id");
    id_read(19'h30000, "R3 mfg");
    id_read(19'h40001, "R3 dev");
    id_read(19'h000FF, "R3 other");
    for (int s = 0; s < 8; s++) id_read({s[2:0], 8'h00, 8'h02}, "R4 protect");
    wr(19'h00000, 8'hF0, "R2 reset from id");
    id_read(19'h00000, "R2 read after reset");

    unlock(8'hA0, "R5 setup");
    wr(19'h5A5A5, 8'hC3, "R5 R7 data");
    wr(hi(11'h555), 8'hAA, "R8 ignored");
    wr(hi(11'h555), 8'hF0, "R8 no timeout");
    done_pulse();

    unlock(8'h80, "R6 setup");
    unlock(8'h10, "R6 erase");
    eng_timeout = 1'b1; m_to = 1;
    wr(19'h00001, 8'h55, "R10 non reset");
    wr(19'h00002, 8'hF0, "R10 reset");

    wr(hi(11'h555), 8'hAA, "R9 u1");
    wr(hi(11'h555), 8'h55, "R9 bad u2");
    unlock(8'h77, "R9 bad cmd");
    unlock(8'h80, "R9 erase setup");
    wr(hi(11'h555), 8'hAA, "R9");
    wr(hi(11'h2AA), 8'h55, "R9");
    wr(hi(11'h555), 8'h11, "R9 bad erase");

    for (int i = 0; i < 300; i++) begin
      int op = $urandom % 8;
      if (m_mode >= 2) begin
        case ($urandom % 4)
          0: done_pulse();
          1: begin eng_timeout = 1'b1; m_to = 1; wr(19'($urandom), 8'hF0, "R10 rand"); end
          default: unlock(8'hA0, "R8 rand");
        endcase
      end else case (op)
        0: begin unlock(8'hA0, "R5 rand"); wr(19'($urandom), 8'($urandom), "R5 rand"); end
        1: begin unlock(8'h80, "R6 rand"); unlock(8'h10, "R6 rand"); end
        2: unlock(8'h90, "R3 rand");
        3: wr(19'($urandom), 8'($urandom), "R9 rand");
        4: begin wr(hi(11'h555), 8'hAA, "R9 rand"); wr(19'($urandom), 8'($urandom), "R9 rand"); end
        5: wr(19'($urandom), 8'hF0, "R2 rand");
        default: id_read({3'($urandom), 14'($urandom), 2'($urandom)} & 19'h700FF, "R3 R4 rand");
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule